// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a list of up to sixteen transfers without a processor stepping in between them. Each list entry has three parts: a command byte, a transmit word and a receive word. All three are held in small internal memories that the host fills through a plain write/read port. The command byte chooses which chip-select lines are driven during the entry. It also chooses the transfer width, whether the chip selects stay asserted into the next entry, and whether extra delay is added before the first clock edge or after the last one.

The host programs four things: a clock divider, the first and last entry of the queue, whether the queue restarts when it reaches its last entry, and where it restarts. Setting the enable bit starts the run. The controller then walks the entries in order and stores each received word in that entry's receive slot. It raises a completion flag and reports the index of the last entry it finished. A halt request stops the controller only between entries. Pointer changes made while a queue runs are held back until the queue reaches a boundary.

The host port is a single-cycle register and memory port with no back-pressure: a write is taken on the clock edge where `host_we` is high, and read data is presented combinationally for `host_addr`. The serial pins are plain outputs and one input.

Top module: `qspi_master`

Host address map: `host_addr[5:4]` selects the area (0 registers, 1 command bytes, 2 transmit words, 3 receive words, read-only) and `host_addr[3:0]` the entry or register. Registers: 0 divider; 1 pending pointers {bit9 restart-at-first-entry, bit8 restart enable, [7:4] last entry, [3:0] first entry}; 2 control {bit1 halt, bit0 enable}; 3 status {[7:4] last finished entry, bit1 halted, bit0 queue done; writing 1 to bit0 clears it}.

## Requirements
- R1: After reset the divider reads 4, the pointer, control and status registers read 0, every chip-select line is high and SCK is low.
- R2: With divider value D (2 to 255), SCK rises every 2·D system clocks during a transfer.
- R3: While the divider is 0 or 1 no transfer starts and SCK stays low; enable stays set, and writing a valid divider lets the queue run.
- R4: Transfers are SPI mode 0, MSB first. MOSI is valid at each rising SCK edge and MISO is sampled there. An 8-bit transfer sends the low byte of the transmit word, and its receive word has the upper byte zero.
- R5: Command byte layout: [3:0] chip-select levels driven while the entry runs; bit 7 set selects a 16-bit transfer, clear an 8-bit one. Chip selects do not change on any SCK edge.
- R6: Command bit 4 (continue) clear returns all chip selects high after the entry. When it is set, the lines are held into the next entry. Chip selects are always high when the queue stops.
- R7: Command bit 5 lengthens the gap from chip-select assertion to the first rising SCK edge by 3·D clocks. Command bit 6 lengthens the gap from the last falling edge to chip-select release by 4·D clocks.
- R8: The queue runs from the first entry to the last entry. After the last entry it sets status bit 0, reports that index in status [7:4] and, without restart, clears the enable bit.
- R9: With restart enabled the queue continues after its last entry, at entry 0 when bit 9 is 0 or at the first entry when bit 9 is 1. Enable stays set and status bit 0 is set on every pass.
- R10: Halt takes effect only after the current entry completes. The controller then reports status bit 1, holds chip selects high and starts nothing. Clearing halt resumes with the next entry.
- R11: Pointer register writes made during a run do not change that run; they read back at once and apply when the next queue starts or restarts.
- R12: When the queue completes in the same cycle as a host write that clears status bit 0, the bit ends set.
- R13: The entry after index 15 is index 0, so a queue may wrap through the top of the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe, taken on the rising clock edge |
| host_addr | input | 6 | Area select [5:4] and index [3:0] |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Combinational read data for host_addr |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Chip-select lines, idle high |

## Verification
Two actions can land on the same edge: the controller setting the queue-done flag, and a host write that clears it. The bench provokes this by writing the clear every cycle while a one-entry queue runs, stopping only once the flag reads back as set. If the clear were allowed to win, the flag would never be seen and the poll would time out, which counts as a failure. A second overlap, a pointer write landing during a running queue, is judged by the index of the last entry that finishes.

// File: rtl/qspi_pkg.sv
`timescale 1ns/1ps
package qspi_pkg;
  localparam int CMD_W     = 8;
  localparam int CS_W      = 4;
  localparam int CMD_CONT  = 4;
  localparam int CMD_LEAD  = 5;
  localparam int CMD_TRAIL = 6;
  localparam int CMD_WIDE  = 7;

  typedef enum logic [1:0] {REG_AREA = 2'd0, CMD_AREA = 2'd1, TX_AREA = 2'd2, RX_AREA = 2'd3} area_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_NEXT, SQ_RUN, SQ_HALT} seq_state_e;
  typedef enum logic [1:0] {SH_IDLE, SH_LEAD, SH_SHIFT, SH_TRAIL} shf_state_e;
endpackage

// File: rtl/qspi_baud.sv
`timescale 1ns/1ps
module qspi_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic             ok
);
  logic [DIV_W-1:0] cnt;

  assign ok   = (div >= DIV_W'(2));
  assign tick = run && ok && (cnt == div - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/qspi_shifter.sv
`timescale 1ns/1ps
module qspi_shifter import qspi_pkg::*; #(
  parameter int DATA_W       = 16,
  parameter int HC_W         = 4,
  parameter int LEAD_HALVES  = 4,
  parameter int TRAIL_HALVES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wide,
  input  logic              lead_ext,
  input  logic              trail_ext,
  input  logic [DATA_W-1:0] tx,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rx
);
  localparam int HALF = DATA_W / 2;
  localparam int BC_W = $clog2(DATA_W + 1);

  shf_state_e        st;
  logic [DATA_W-1:0] sr_tx, sr_rx;
  logic [BC_W-1:0]   bits;
  logic [HC_W-1:0]   hcnt;
  logic              trail_q, wide_q;

  assign busy = (st != SH_IDLE);
  assign mosi = sr_tx[DATA_W-1];
  assign rx   = wide_q ? sr_rx : {{HALF{1'b0}}, sr_rx[HALF-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SH_IDLE; sr_tx <= '0; sr_rx <= '0; bits <= '0; hcnt <= '0;
      trail_q <= 1'b0; wide_q <= 1'b0; sck <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SH_IDLE: if (start) begin
          sr_tx   <= wide ? tx : {tx[HALF-1:0], {HALF{1'b0}}};
          sr_rx   <= '0;
          bits    <= wide ? BC_W'(DATA_W) : BC_W'(HALF);
          hcnt    <= lead_ext ? HC_W'(LEAD_HALVES) : HC_W'(1);
          trail_q <= trail_ext;
          wide_q  <= wide;
          st      <= SH_LEAD;
        end
        SH_LEAD: if (tick) begin
          if (hcnt == HC_W'(1)) begin
            sck   <= 1'b1;
            sr_rx <= {sr_rx[DATA_W-2:0], miso};
            st    <= SH_SHIFT;
          end else hcnt <= hcnt - 1'b1;
        end
        SH_SHIFT: if (tick) begin
          if (sck) begin
            sck  <= 1'b0;
            bits <= bits - 1'b1;
            if (bits == BC_W'(1)) begin
              st   <= SH_TRAIL;
              hcnt <= trail_q ? HC_W'(TRAIL_HALVES) : '0;
            end else sr_tx <= sr_tx << 1;
          end else begin
            sck   <= 1'b1;
            sr_rx <= {sr_rx[DATA_W-2:0], miso};
          end
        end
        SH_TRAIL: begin
          if (hcnt == '0) begin
            done <= 1'b1;
            st   <= SH_IDLE;
          end else if (tick) hcnt <= hcnt - 1'b1;
        end
        default: st <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qspi_seq.sv
`timescale 1ns/1ps
module qspi_seq import qspi_pkg::*; #(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             halt,
  input  logic             baud_ok,
  input  logic [PTR_W-1:0] pend_start,
  input  logic [PTR_W-1:0] pend_end,
  input  logic             pend_wrap,
  input  logic             pend_wrto,
  input  logic [CMD_W-1:0] cmd_cur,
  input  logic             xfer_done,
  output logic [PTR_W-1:0] ptr,
  output logic             xfer_start,
  output logic [CS_W-1:0]  cs_n,
  output logic             queue_done,
  output logic             queue_stop,
  output logic             halted
);
  seq_state_e       st;
  logic [PTR_W-1:0] act_end;
  logic             act_wrap;

  assign halted = (st == SQ_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_IDLE; ptr <= '0; act_end <= '0; act_wrap <= 1'b0;
      xfer_start <= 1'b0; cs_n <= '1; queue_done <= 1'b0; queue_stop <= 1'b0;
    end else begin
      xfer_start <= 1'b0;
      queue_done <= 1'b0;
      queue_stop <= 1'b0;
      case (st)
        SQ_IDLE: begin
          cs_n <= '1;
          if (en && !halt && !queue_stop) begin
            act_end  <= pend_end;
            act_wrap <= pend_wrap;
            ptr      <= pend_start;
            st       <= SQ_NEXT;
          end
        end
        SQ_NEXT: begin
          if (!en) begin
            cs_n <= '1; st <= SQ_IDLE;
          end else if (halt) begin
            cs_n <= '1; st <= SQ_HALT;
          end else if (baud_ok) begin
            cs_n       <= cmd_cur[CS_W-1:0];
            xfer_start <= 1'b1;
            st         <= SQ_RUN;
          end
        end
        SQ_RUN: if (xfer_done) begin
          if (ptr == act_end) begin
            queue_done <= 1'b1;
            if (act_wrap) begin
              act_end  <= pend_end;
              act_wrap <= pend_wrap;
              ptr      <= pend_wrto ? pend_start : '0;
              st       <= SQ_NEXT;
              if (!cmd_cur[CMD_CONT]) cs_n <= '1;
            end else begin
              queue_stop <= 1'b1;
              cs_n       <= '1;
              st         <= SQ_IDLE;
            end
          end else begin
            ptr <= ptr + 1'b1;
            st  <= SQ_NEXT;
            if (!cmd_cur[CMD_CONT]) cs_n <= '1;
          end
        end
        SQ_HALT: begin
          cs_n <= '1;
          if (!en)        st <= SQ_IDLE;
          else if (!halt) st <= SQ_NEXT;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qspi_master.sv
`timescale 1ns/1ps
module qspi_master import qspi_pkg::*; #(
  parameter int DATA_W       = 16,
  parameter int DIV_W        = 8,
  parameter int DIV_RST      = 4,
  parameter int PTR_W        = 4,
  parameter int HC_W         = 4,
  parameter int LEAD_HALVES  = 4,
  parameter int TRAIL_HALVES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [PTR_W+1:0]  host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [CS_W-1:0]   spi_cs_n
);
  localparam int DEPTH = 1 << PTR_W;
  localparam int QP_W  = 2 * PTR_W + 2;

  logic [DIV_W-1:0]  div_q;
  logic [PTR_W-1:0]  pstart_q, pend_q, cptr_q;
  logic              pwrap_q, pwrto_q, en_q, halt_q, done_f;
  logic [CMD_W-1:0]  cmd_ram [DEPTH];
  logic [DATA_W-1:0] tx_ram  [DEPTH];
  logic [DATA_W-1:0] rx_ram  [DEPTH];

  area_e             area;
  logic [PTR_W-1:0]  idx;
  logic              wr_reg;
  logic [PTR_W-1:0]  seq_ptr;
  logic              seq_start, seq_qdone, seq_qstop, seq_halted;
  logic              baud_tick, baud_ok, shf_busy, shf_done;
  logic [DATA_W-1:0] shf_rx;
  logic [CMD_W-1:0]  cmd_cur;

  assign area    = area_e'(host_addr[PTR_W+1:PTR_W]);
  assign idx     = host_addr[PTR_W-1:0];
  assign wr_reg  = host_we && (area == REG_AREA);
  assign cmd_cur = cmd_ram[seq_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(DIV_RST);
      {pwrto_q, pwrap_q, pend_q, pstart_q} <= '0;
      en_q <= 1'b0; halt_q <= 1'b0; done_f <= 1'b0; cptr_q <= '0;
    end else begin
      if (wr_reg && idx == PTR_W'(0)) div_q <= host_wdata[DIV_W-1:0];
      if (wr_reg && idx == PTR_W'(1)) {pwrto_q, pwrap_q, pend_q, pstart_q} <= host_wdata[QP_W-1:0];
      if (seq_qstop)                       en_q <= 1'b0;
      else if (wr_reg && idx == PTR_W'(2)) en_q <= host_wdata[0];
      if (wr_reg && idx == PTR_W'(2)) halt_q <= host_wdata[1];
      if (seq_qdone) done_f <= 1'b1;
      else if (wr_reg && idx == PTR_W'(3) && host_wdata[0]) done_f <= 1'b0;
      if (shf_done) cptr_q <= seq_ptr;
    end
  end

  always_ff @(posedge clk) begin
    if (host_we && area == CMD_AREA) cmd_ram[idx] <= host_wdata[CMD_W-1:0];
    if (host_we && area == TX_AREA)  tx_ram[idx]  <= host_wdata;
    if (shf_done)                    rx_ram[seq_ptr] <= shf_rx;
  end

  always_comb begin
    host_rdata = '0;
    case (area)
      REG_AREA: begin
        if (idx == PTR_W'(0)) host_rdata[DIV_W-1:0] = div_q;
        if (idx == PTR_W'(1)) host_rdata[QP_W-1:0]  = {pwrto_q, pwrap_q, pend_q, pstart_q};
        if (idx == PTR_W'(2)) host_rdata[1:0]       = {halt_q, en_q};
        if (idx == PTR_W'(3)) host_rdata[PTR_W+3:0] = {cptr_q, 2'b00, seq_halted, done_f};
      end
      CMD_AREA: host_rdata[CMD_W-1:0] = cmd_ram[idx];
      TX_AREA:  host_rdata = tx_ram[idx];
      default:  host_rdata = rx_ram[idx];
    endcase
  end

  qspi_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(shf_busy), .div(div_q), .tick(baud_tick), .ok(baud_ok)
  );

  qspi_shifter #(.DATA_W(DATA_W), .HC_W(HC_W), .LEAD_HALVES(LEAD_HALVES), .TRAIL_HALVES(TRAIL_HALVES)) u_shf (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .wide(cmd_cur[CMD_WIDE]),
    .lead_ext(cmd_cur[CMD_LEAD]), .trail_ext(cmd_cur[CMD_TRAIL]), .tx(tx_ram[seq_ptr]),
    .tick(baud_tick), .miso(spi_miso), .busy(shf_busy), .sck(spi_sck), .mosi(spi_mosi),
    .done(shf_done), .rx(shf_rx)
  );

  qspi_seq #(.PTR_W(PTR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en_q), .halt(halt_q), .baud_ok(baud_ok),
    .pend_start(pstart_q), .pend_end(pend_q), .pend_wrap(pwrap_q), .pend_wrto(pwrto_q),
    .cmd_cur(cmd_cur), .xfer_done(shf_done), .ptr(seq_ptr), .xfer_start(seq_start),
    .cs_n(spi_cs_n), .queue_done(seq_qdone), .queue_stop(seq_qstop), .halted(seq_halted)
  );
endmodule

// File: rtl/qspi_master_chk.sv
`timescale 1ns/1ps
module qspi_master_chk #(
  parameter int DIV_W = 8,
  parameter int CS_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sck,
  input logic [CS_W-1:0]  cs_n,
  input logic [DIV_W-1:0] div,
  input logic             halted,
  input logic             qstop,
  input logic             qdone,
  input logic             en,
  input logic             done_f
);
  // R6: no clock while every chip select is idle
  p_sck_low_deselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == '1) |-> !sck);
  // R5: chip selects never move on an SCK edge
  p_cs_stable_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sck != $past(sck)) |-> (cs_n == $past(cs_n)));
  // R3: an invalid divider keeps SCK low
  p_no_sck_div_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((div < DIV_W'(2)) && !sck) |=> !sck);
  // R10: halted controller holds chip selects idle
  p_halt_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (cs_n == '1));
  // R8: a finished queue without restart drops enable
  p_stop_clears_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    qstop |=> !en);
  // R12: completion beats a same-cycle clear
  p_done_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    qdone |=> done_f);
endmodule

bind qspi_master qspi_master_chk #(.DIV_W(DIV_W), .CS_W(qspi_pkg::CS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .div(div_q),
  .halted(seq_halted), .qstop(seq_qstop), .qdone(seq_qdone), .en(en_q), .done_f(done_f)
);

// File: tb/tb_qspi_master.sv
`timescale 1ns/1ps
module tb_qspi_master;
  localparam int LEAD = 4;
  localparam int TRAIL = 4;
  localparam real TCK = 5.0;

  logic clk = 1'b0, rst_n = 1'b0, host_we = 1'b0, miso_inv = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [15:0] host_wdata = '0, host_rdata;
  logic spi_sck, spi_mosi, spi_miso;
  logic [3:0] spi_cs_n;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;
  assign spi_miso = spi_mosi ^ miso_inv;

  qspi_master dut (.clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  // serial-side monitors, driven only by output changes
  logic [15:0] cap = '0;
  int rise_cnt = 0, rel_cnt = 0;
  realtime rise_last = 0, rise_prev = 0, first_rise = 0, cs_on_t = 0, last_fall = 0, rel_t = 0;
  bit got_first = 0, cs_idle = 1;
  always @(posedge spi_sck) begin
    cap = {cap[14:0], spi_mosi};
    rise_prev = rise_last; rise_last = $realtime; rise_cnt++;
    if (!got_first) begin first_rise = $realtime; got_first = 1; end
  end
  always @(negedge spi_sck) last_fall = $realtime;
  always @(spi_cs_n) begin
    if (spi_cs_n == 4'hF) begin rel_cnt++; rel_t = $realtime; cs_idle = 1; end
    else if (cs_idle) begin cs_on_t = $realtime; got_first = 0; cs_idle = 0; end
  end

  function automatic logic [5:0] ad(input int area, input int i);
    return {2'(area), 4'(i)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); host_addr = a; #0.5; d = host_rdata;
  endtask

  task automatic wait_stat(input int bitn, input int limit, output bit seen);
    logic [15:0] s;
    seen = 0;
    for (int k = 0; k < limit && !seen; k++) begin rd(ad(0,3), s); seen = s[bitn]; end
  endtask

  task automatic run_q(input int s, input int e, input int wrap, input int wrto);
    wr(ad(0,3), 16'h1);
    wr(ad(0,1), 16'((wrto << 9) | (wrap << 8) | (e << 4) | s));
    wr(ad(0,2), 16'h1);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(ad(0,0), d); chk("R1 divider reset", d, 16'h4);
    rd(ad(0,1), d); chk("R1 pointer reset", d, 0);
    rd(ad(0,2), d); chk("R1 control reset", d, 0);
    rd(ad(0,3), d); chk("R1 status reset", d, 0);
    chk("R1 cs idle", spi_cs_n, 4'hF);
    chk("R1 sck low", spi_sck, 0);
  endtask

  task automatic t_single;
    logic [15:0] d; bit seen;
    wr(ad(1,0), 16'h0E); wr(ad(2,0), 16'hBEA5);
    run_q(0, 0, 0, 0);
    wait (spi_cs_n != 4'hF); #1;
    chk("R5 cs pattern", spi_cs_n, 4'hE);
    wait_stat(0, 400, seen); chk("R8 done seen", seen, 1);
    rd(ad(0,3), d); chk("R8 status and last entry", d, 16'h01);
    rd(ad(0,2), d); chk("R8 enable cleared", d, 0);
    rd(ad(3,0), d); chk("R4 rx 8-bit", d, 16'h00A5);
    chk("R4 mosi msb first", cap[7:0], 8'hA5);
    chk("R2 sck period div4", int'((rise_last - rise_prev) / TCK), 8);
  endtask

  task automatic t_wide_wrapidx;
    logic [15:0] d; bit seen;
    miso_inv = 1; wr(ad(0,0), 16'd3);
    wr(ad(1,14), 16'h87); wr(ad(1,15), 16'h87); wr(ad(1,0), 16'h87);
    wr(ad(2,14), 16'h1234); wr(ad(2,15), 16'hF00D); wr(ad(2,0), 16'h8001);
    run_q(14, 0, 0, 0);
    wait_stat(0, 1000, seen); chk("R13 done seen", seen, 1);
    rd(ad(0,3), d); chk("R13 last entry 0", d[7:4], 0);
    rd(ad(3,14), d); chk("R4 rx wide inverted e14", d, 16'hEDCB);
    rd(ad(3,15), d); chk("R13 rx e15", d, 16'h0FF2);
    rd(ad(3,0), d); chk("R13 rx e0 after wrap", d, 16'h7FFE);
    chk("R5 wide mosi", cap, 16'h8001);
    chk("R2 sck period div3", int'((rise_last - rise_prev) / TCK), 6);
    miso_inv = 0;
  endtask

  task automatic t_continue;
    bit seen;
    wr(ad(0,0), 16'd2);
    wr(ad(1,0), 16'h1D); wr(ad(1,1), 16'h0D); wr(ad(1,2), 16'h0B);
    rel_cnt = 0;
    run_q(0, 2, 0, 0);
    wait_stat(0, 1000, seen);
    repeat (4) @(negedge clk);
    chk("R6 releases with continue", rel_cnt, 2);
  endtask

  task automatic one_entry(input logic [7:0] cmd, output int lead, output int trail);
    bit seen;
    wr(ad(1,0), 16'(cmd));
    run_q(0, 0, 0, 0);
    wait_stat(0, 1000, seen);
    lead = int'((first_rise - cs_on_t) / TCK);
    trail = int'((rel_t - last_fall) / TCK);
  endtask

  task automatic t_delays;
    int l0, t0, l1, t1, lx, tx;
    one_entry(8'h0E, l0, t0);
    one_entry(8'h2E, l1, tx);
    one_entry(8'h4E, lx, t1);
    chk("R7 lead extension", l1 - l0, (LEAD - 1) * 2);
    chk("R7 trail extension", t1 - t0, TRAIL * 2);
  endtask

  task automatic t_wrap;
    logic [15:0] d; bit seen;
    for (int i = 0; i < 3; i++) wr(ad(1,i), 16'h0E);
    wr(ad(2,0), 16'h3C);
    run_q(1, 2, 1, 0);
    wait_stat(0, 1000, seen); chk("R9 first pass", seen, 1);
    rd(ad(0,2), d); chk("R9 enable kept", d[0], 1);
    wr(ad(0,3), 16'h1);
    wait_stat(0, 1000, seen); chk("R9 second pass", seen, 1);
    wr(ad(0,2), 16'h0); repeat (100) @(negedge clk);
    rd(ad(3,0), d); chk("R9 restart at entry 0", d, 16'h3C);
    wr(ad(2,0), 16'h77);
    run_q(1, 2, 1, 1);
    wait_stat(0, 1000, seen); wr(ad(0,3), 16'h1);
    wait_stat(0, 1000, seen); chk("R9 second pass to first", seen, 1);
    wr(ad(0,2), 16'h0); repeat (100) @(negedge clk);
    rd(ad(3,0), d); chk("R9 entry 0 skipped", d, 16'h3C);
  endtask

  task automatic t_halt;
    logic [15:0] d; bit seen;
    for (int i = 0; i < 4; i++) wr(ad(1,i), 16'h1E);
    run_q(0, 3, 0, 0);
    wr(ad(0,2), 16'h3);
    wait_stat(1, 400, seen); chk("R10 halt ack", seen, 1);
    rd(ad(0,3), d); chk("R10 stopped after entry 0", d, 16'h02);
    chk("R10 cs idle halted", spi_cs_n, 4'hF);
    repeat (100) @(negedge clk);
    rd(ad(0,3), d); chk("R10 nothing runs while halted", d, 16'h02);
    wr(ad(0,2), 16'h1);
    wait_stat(0, 1000, seen); rd(ad(0,3), d); chk("R10 resumes to end", d, 16'h31);
  endtask

  task automatic t_buffered;
    logic [15:0] d; bit seen;
    wr(ad(1,5), 16'h0E); wr(ad(2,5), 16'h5C);
    run_q(0, 3, 0, 0);
    wr(ad(0,1), 16'h55);
    rd(ad(0,1), d); chk("R11 pending readback", d, 16'h55);
    wait_stat(0, 1000, seen);
    rd(ad(0,3), d); chk("R11 run kept old end", d[7:4], 3);
    wr(ad(0,3), 16'h1); wr(ad(0,2), 16'h1);
    wait_stat(0, 1000, seen);
    rd(ad(0,3), d); chk("R11 new queue applied", d[7:4], 5);
    rd(ad(3,5), d); chk("R11 new entry data", d, 16'h5C);
  endtask

  task automatic t_div_off;
    logic [15:0] d; bit seen; int r0;
    wr(ad(0,0), 16'd1); r0 = rise_cnt;
    run_q(0, 0, 0, 0);
    repeat (200) @(negedge clk);
    chk("R3 no sck edges", rise_cnt - r0, 0);
    rd(ad(0,3), d); chk("R3 no completion", d[0], 0);
    rd(ad(0,2), d); chk("R3 enable kept", d[0], 1);
    wr(ad(0,0), 16'd2);
    wait_stat(0, 1000, seen); chk("R3 runs after valid divider", seen, 1);
  endtask

  task automatic t_collide;
    bit seen = 0;
    wr(ad(0,3), 16'h1);
    wr(ad(0,1), 16'h0); wr(ad(0,2), 16'h1);
    @(negedge clk); host_addr = ad(0,3); host_wdata = 16'h1; host_we = 1;
    for (int k = 0; k < 1000 && !seen; k++) begin
      @(negedge clk); #0.5; seen = host_rdata[0];
    end
    host_we = 0;
    chk("R12 set wins over clear", seen, 1);
  endtask

  initial begin
    #(TCK * 150000);
    nfail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk); rst_n = 1;
    t_reset; t_single; t_wide_wrapidx; t_continue; t_delays;
    t_wrap; t_halt; t_buffered; t_div_off; t_collide;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule